// File: doc/BRIEF.md
# Hop-Addressed Indirect Configuration Access Engine

This block gives a host a narrow window into configuration registers spread over several hop-addressed targets. The host sees two registers: a data word and a command word. To write a target, the host loads the data word first and then writes the command word. To read a target, the host writes only the command word. Writing the command word starts the operation. The host then polls two flags in the command word until the operation has finished.

The engine decodes a sub-command, a local/remote flag, a destination hop, an address-space select and a six-bit register offset. Local accesses go to a small register file that the engine holds for each local hop, plus a PHY register bank on one hop. Remote accesses, ID-assign requests and circular writes go out on a request port that uses a valid/ready handshake. A matching response returns on a response port. For PHY-space accesses, the two upper offset bits come from bits [28:27] of a PHY control register. That register is controller register `PHYCTL_IDX` of hop `PHY_HOP`.

The controller is a four-state machine:
- `ST_IDLE` waits for a command write (transition *start*).
- `ST_EXEC` decodes the command. It then finishes a local access (transition *local_done*) or moves on to the remote leg (transition *forward*).
- `ST_REQ` holds the request until it is accepted (transition *accepted*).
- `ST_RSP` waits for the response (transition *answered*) and then returns to `ST_IDLE`.

Top module: `hce_engine`

## Requirements
- R1: After reset the data word and the command word are zero. The error flag is clear, the block is not busy and no remote request is valid.
- R2: Writing the data word (host_sel=0) while idle only loads it. Writing the command word (host_sel=1) while idle loads it with bits 6 (done) and 7 (data-ready) cleared, and the block is busy from the next cycle.
- R3: A local access completes one cycle after the command is loaded: done is set and busy is clear. Each local hop has its own controller registers. A read returns the value last written to the same hop and offset. Command fields: [3:0] sub-command (0 write, 1 read, 2 ID-assign, 3 circular write), bit 5 local, [15:8] hop, [23:22] space (0 controller, 3 PHY), [21:16] low offset.
- R4: A completed write sets done and leaves data-ready clear.
- R5: For space 3 the full offset is {PHY control bits [28:27], command bits [21:16]}. This holds for local PHY accesses and for the offset sent with a remote request.
- R6: A local access to an unimplemented hop, offset or space, or any sub-command above 3, completes with done set and sets the error flag. A read of this kind also sets data-ready and loads zero into the data word.
- R7: A host write of either word while an operation is in flight leaves both words unchanged and sets the error flag. The error flag stays set until reset.
- R8: A remote write (bit 5 = 0) raises a request that carries the sub-command, hop, offset and data word. Done is set only in the cycle after the response is accepted.
- R9: A remote read loads the response data into the data word and sets done and data-ready together.
- R10: A circular write updates the local register at the same hop and offset, is also forwarded as a request with sub-command 3, and completes only after the response.
- R11: An ID-assign request is always forwarded with sub-command 2, even when the local flag is set.
- R12: While a request is valid and not yet accepted, it stays valid and all of its fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 selects the data word, 1 selects the command word |
| host_wdata | input | 32 | Host write value |
| data_reg | output | 32 | Current data word |
| cmd_reg | output | 32 | Current command word, with done in bit 6 and data-ready in bit 7 |
| err_sticky | output | 1 | Sticky error flag |
| busy | output | 1 | An operation is in flight |
| rreq_valid | output | 1 | Remote request valid |
| rreq_ready | input | 1 | Remote request accepted |
| rreq_op | output | 2 | Forwarded sub-command |
| rreq_hop | output | 8 | Destination hop |
| rreq_space | output | 2 | Address space |
| rreq_offset | output | 8 | Full register offset |
| rreq_wdata | output | 32 | Data word carried with the request |
| rrsp_valid | input | 1 | Remote response valid |
| rrsp_ready | output | 1 | Engine is waiting for a response |
| rrsp_rdata | input | 32 | Remote response data |

## Verification
The bench holds the request unaccepted for several cycles. A design that raised done on acceptance rather than on the response, or that let the request fields drift while stalled, is caught there.

Commands and data words written in mid-flight must leave both words intact. A design that let a late write through would forward a corrupted data word or overwrite the pending command.

The PHY offset check reprograms the control bits between two accesses at the same low offset. A design that ignored those bits would send offset 0x02 instead of 0x42, or would read a live register where zero is expected.

The error cases read back into a data word preloaded with ones. A design that skipped the zero load on a failed read, or set data-ready for a failed write or an unknown sub-command, is exposed.

// File: rtl/hce_pkg.sv
package hce_pkg;
    localparam int DATA_W = 32;

    localparam logic [3:0] SUB_WRITE  = 4'd0;
    localparam logic [3:0] SUB_READ   = 4'd1;
    localparam logic [3:0] SUB_ASSIGN = 4'd2;
    localparam logic [3:0] SUB_CIRC   = 4'd3;

    localparam logic [1:0] SPACE_CTRL = 2'd0;
    localparam logic [1:0] SPACE_PHY  = 2'd3;

    typedef enum logic [2:0] {
        ACT_LWRITE,
        ACT_LREAD,
        ACT_REMOTE,
        ACT_CIRC,
        ACT_BAD
    } act_e;

    typedef struct packed {
        act_e       act;
        logic       rd;
        logic       space_ok;
        logic       is_phy;
        logic [7:0] hop;
        logic [1:0] space;
        logic [7:0] offset;
        logic [1:0] op;
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_REQ,
        ST_RSP
    } state_e;
endpackage

// File: rtl/hce_decode.sv
module hce_decode
    import hce_pkg::*;
(
    input  logic [3:0] sub,
    input  logic       is_local,
    input  logic [7:0] hop,
    input  logic [1:0] space,
    input  logic [5:0] low_off,
    input  logic [1:0] phy_hi,
    output dec_t       dec
);
    always_comb begin
        dec          = '0;
        dec.hop      = hop;
        dec.space    = space;
        dec.op       = sub[1:0];
        dec.is_phy   = (space == SPACE_PHY);
        dec.space_ok = (space == SPACE_PHY) || (space == SPACE_CTRL);
        dec.offset   = dec.is_phy ? {phy_hi, low_off} : {2'b00, low_off};
        dec.rd       = (sub == SUB_READ);
        unique case (sub)
            SUB_WRITE:  dec.act = !is_local ? ACT_REMOTE : (dec.space_ok ? ACT_LWRITE : ACT_BAD);
            SUB_READ:   dec.act = !is_local ? ACT_REMOTE : (dec.space_ok ? ACT_LREAD : ACT_BAD);
            SUB_ASSIGN: dec.act = ACT_REMOTE;
            SUB_CIRC:   dec.act = ACT_CIRC;
            default:    dec.act = ACT_BAD;
        endcase
    end
endmodule

// File: rtl/hce_regs.sv
module hce_regs
    import hce_pkg::*;
#(
    parameter int LOCAL_HOPS = 2,
    parameter int CTRL_REGS  = 8,
    parameter int PHY_REGS   = 8,
    parameter int PHY_HOP    = 0,
    parameter int PHYCTL_IDX = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        hop,
    input  logic              is_phy,
    input  logic [7:0]        offset,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              hit,
    output logic [1:0]        phy_hi
);
    localparam int HW = (LOCAL_HOPS > 1) ? $clog2(LOCAL_HOPS) : 1;
    localparam int CW = (CTRL_REGS > 1) ? $clog2(CTRL_REGS) : 1;
    localparam int PW = (PHY_REGS > 1) ? $clog2(PHY_REGS) : 1;
    localparam logic [7:0] HOP_LIM  = 8'(LOCAL_HOPS);
    localparam logic [7:0] CTRL_LIM = 8'(CTRL_REGS);
    localparam logic [7:0] PHY_LIM  = 8'(PHY_REGS);
    localparam logic [7:0] PHY_ID   = 8'(PHY_HOP);

    logic ctrl_hit, phy_hit;
    assign ctrl_hit = (hop < HOP_LIM) && !is_phy && (offset < CTRL_LIM);
    assign phy_hit  = is_phy && (hop == PHY_ID) && (offset < PHY_LIM);
    assign hit      = ctrl_hit || phy_hit;

    logic [DATA_W-1:0] ctrl_rd [LOCAL_HOPS];

    for (genvar h = 0; h < LOCAL_HOPS; h++) begin : g_hop
        logic [DATA_W-1:0] mem [CTRL_REGS];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < CTRL_REGS; i++) mem[i] <= '0;
            end else if (wr_en && ctrl_hit && hop == 8'(h)) begin
                mem[offset[CW-1:0]] <= wdata;
            end
        end
        assign ctrl_rd[h] = mem[offset[CW-1:0]];
        if (h == PHY_HOP) begin : g_phyctl
            assign phy_hi = mem[PHYCTL_IDX][28:27];
        end
    end

    logic [DATA_W-1:0] phy_mem [PHY_REGS];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PHY_REGS; i++) phy_mem[i] <= '0;
        end else if (wr_en && phy_hit) begin
            phy_mem[offset[PW-1:0]] <= wdata;
        end
    end

    always_comb begin
        if (ctrl_hit)     rdata = ctrl_rd[hop[HW-1:0]];
        else if (phy_hit) rdata = phy_mem[offset[PW-1:0]];
        else              rdata = '0;
    end
endmodule

// File: rtl/hce_engine.sv
module hce_engine
    import hce_pkg::*;
#(
    parameter int LOCAL_HOPS = 2,
    parameter int CTRL_REGS  = 8,
    parameter int PHY_REGS   = 8,
    parameter int PHY_HOP    = 0,
    parameter int PHYCTL_IDX = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] data_reg,
    output logic [31:0]       cmd_reg,
    output logic              err_sticky,
    output logic              busy,
    output logic              rreq_valid,
    input  logic              rreq_ready,
    output logic [1:0]        rreq_op,
    output logic [7:0]        rreq_hop,
    output logic [1:0]        rreq_space,
    output logic [7:0]        rreq_offset,
    output logic [DATA_W-1:0] rreq_wdata,
    input  logic              rrsp_valid,
    output logic              rrsp_ready,
    input  logic [DATA_W-1:0] rrsp_rdata
);
    localparam int DONE_BIT = 6;
    localparam int RDY_BIT  = 7;

    state_e            state, state_nx;
    logic [DATA_W-1:0] data_r;
    logic [31:0]       cmd_r;
    logic              err_r;
    dec_t              dec;
    logic [1:0]        phy_hi;
    logic [DATA_W-1:0] loc_rdata;
    logic              reg_hit, loc_ok, loc_we;

    hce_decode i_decode (
        .sub      (cmd_r[3:0]),
        .is_local (cmd_r[5]),
        .hop      (cmd_r[15:8]),
        .space    (cmd_r[23:22]),
        .low_off  (cmd_r[21:16]),
        .phy_hi   (phy_hi),
        .dec      (dec)
    );

    hce_regs #(
        .LOCAL_HOPS (LOCAL_HOPS),
        .CTRL_REGS  (CTRL_REGS),
        .PHY_REGS   (PHY_REGS),
        .PHY_HOP    (PHY_HOP),
        .PHYCTL_IDX (PHYCTL_IDX)
    ) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (loc_we),
        .hop    (dec.hop),
        .is_phy (dec.is_phy),
        .offset (dec.offset),
        .wdata  (data_r),
        .rdata  (loc_rdata),
        .hit    (reg_hit),
        .phy_hi (phy_hi)
    );

    assign loc_ok = dec.space_ok && reg_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: start, local_done, forward, accepted, answered
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (host_we && host_sel) state_nx = ST_EXEC;
            ST_EXEC: state_nx = (dec.act == ACT_REMOTE || dec.act == ACT_CIRC) ? ST_REQ : ST_IDLE;
            ST_REQ:  if (rreq_ready) state_nx = ST_RSP;
            ST_RSP:  if (rrsp_valid) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy        = (state != ST_IDLE);
        rreq_valid  = (state == ST_REQ);
        rrsp_ready  = (state == ST_RSP);
        loc_we      = (state == ST_EXEC) && loc_ok &&
                      (dec.act == ACT_LWRITE || dec.act == ACT_CIRC);
        rreq_op     = dec.op;
        rreq_hop    = dec.hop;
        rreq_space  = dec.space;
        rreq_offset = dec.offset;
        rreq_wdata  = data_r;
        data_reg    = data_r;
        cmd_reg     = cmd_r;
        err_sticky  = err_r;
    end

    // host-visible registers and completion flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_r <= '0;
            cmd_r  <= '0;
            err_r  <= 1'b0;
        end else begin
            if (host_we) begin
                if (state != ST_IDLE) begin
                    err_r <= 1'b1;
                end else if (host_sel) begin
                    cmd_r <= {host_wdata[31:8], 2'b00, host_wdata[5:0]};
                end else begin
                    data_r <= host_wdata;
                end
            end
            if (state == ST_EXEC) begin
                unique case (dec.act)
                    ACT_LWRITE: begin
                        cmd_r[DONE_BIT] <= 1'b1;
                        if (!loc_ok) err_r <= 1'b1;
                    end
                    ACT_LREAD: begin
                        cmd_r[DONE_BIT] <= 1'b1;
                        cmd_r[RDY_BIT]  <= 1'b1;
                        data_r          <= loc_ok ? loc_rdata : '0;
                        if (!loc_ok) err_r <= 1'b1;
                    end
                    ACT_CIRC: begin
                        if (!loc_ok) err_r <= 1'b1;
                    end
                    ACT_BAD: begin
                        cmd_r[DONE_BIT] <= 1'b1;
                        err_r           <= 1'b1;
                        if (dec.rd) begin
                            cmd_r[RDY_BIT] <= 1'b1;
                            data_r         <= '0;
                        end
                    end
                    default: ;
                endcase
            end
            if (state == ST_RSP && rrsp_valid) begin
                cmd_r[DONE_BIT] <= 1'b1;
                if (dec.rd) begin
                    cmd_r[RDY_BIT] <= 1'b1;
                    data_r         <= rrsp_rdata;
                end
            end
        end
    end
endmodule

// File: rtl/hce_engine_chk.sv
module hce_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_we,
    input logic        host_sel,
    input logic        busy,
    input logic [31:0] cmd_reg,
    input logic        err_sticky,
    input logic        rreq_valid,
    input logic        rreq_ready,
    input logic [1:0]  rreq_op,
    input logic [7:0]  rreq_hop,
    input logic [7:0]  rreq_offset,
    input logic [31:0] rreq_wdata
);
    // R2
    cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_we && host_sel) |=> (busy && cmd_reg[7:6] == 2'b00));

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reg[6] |-> !busy);

    // R4
    write_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmd_reg[6]) && cmd_reg[3:0] != 4'd1) |-> !cmd_reg[7]);

    // R9
    ready_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reg[7] |-> cmd_reg[6]);

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // R8
    req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rreq_valid);

    // R12
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rreq_valid && !rreq_ready) |=> (rreq_valid && $stable(rreq_op) &&
        $stable(rreq_hop) && $stable(rreq_offset) && $stable(rreq_wdata)));
endmodule

bind hce_engine hce_engine_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_we     (host_we),
    .host_sel    (host_sel),
    .busy        (busy),
    .cmd_reg     (cmd_reg),
    .err_sticky  (err_sticky),
    .rreq_valid  (rreq_valid),
    .rreq_ready  (rreq_ready),
    .rreq_op     (rreq_op),
    .rreq_hop    (rreq_hop),
    .rreq_offset (rreq_offset),
    .rreq_wdata  (rreq_wdata)
);

// File: tb/test_hce_engine.sv
module test_hce_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] data_reg, cmd_reg;
    logic        err_sticky, busy;
    logic        rreq_valid, rreq_ready = 1'b0;
    logic [1:0]  rreq_op, rreq_space;
    logic [7:0]  rreq_hop, rreq_offset;
    logic [31:0] rreq_wdata;
    logic        rrsp_valid = 1'b0, rrsp_ready;
    logic [31:0] rrsp_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hce_engine i_hce_engine (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .data_reg(data_reg), .cmd_reg(cmd_reg),
        .err_sticky(err_sticky), .busy(busy), .rreq_valid(rreq_valid),
        .rreq_ready(rreq_ready), .rreq_op(rreq_op), .rreq_hop(rreq_hop),
        .rreq_space(rreq_space), .rreq_offset(rreq_offset),
        .rreq_wdata(rreq_wdata), .rrsp_valid(rrsp_valid),
        .rrsp_ready(rrsp_ready), .rrsp_rdata(rrsp_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] sub, input logic loc,
                                       input logic [7:0] hop, input logic [1:0] sp,
                                       input logic [5:0] lo);
        return {8'h00, sp, lo, hop, 2'b00, loc, 1'b0, sub};
    endfunction

    task automatic hwr(input logic sel, input logic [31:0] val);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = val;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // local command: done visible one negedge after the command is loaded
    task automatic local_cmd(input string req, input logic [31:0] cmd);
        hwr(1'b1, cmd);
        chk({req, " busy after start"}, {31'd0, busy}, 32'd1);
        chk({req, " flags cleared"}, {30'd0, cmd_reg[7:6]}, 32'd0);
        @(negedge clk);
        chk({req, " done"}, {31'd0, cmd_reg[6]}, 32'd1);
        chk({req, " idle"}, {31'd0, busy}, 32'd0);
    endtask

    task automatic remote_cmd(input string req, input logic [31:0] cmd,
                              input logic [1:0] e_op, input logic [7:0] e_hop,
                              input logic [7:0] e_off, input logic [31:0] e_wd,
                              input logic [31:0] rsp);
        hwr(1'b1, cmd);
        @(negedge clk);
        chk({req, " req valid"}, {31'd0, rreq_valid}, 32'd1);
        chk({req, " req op"}, {30'd0, rreq_op}, {30'd0, e_op});
        chk({req, " req hop"}, {24'd0, rreq_hop}, {24'd0, e_hop});
        chk({req, " req offset"}, {24'd0, rreq_offset}, {24'd0, e_off});
        chk({req, " req data"}, rreq_wdata, e_wd);
        repeat (2) @(negedge clk);
        chk({req, " R12 held while stalled"}, {31'd0, rreq_valid}, 32'd1);
        chk({req, " no done while stalled"}, {31'd0, cmd_reg[6]}, 32'd0);
        rreq_ready = 1'b1;
        @(negedge clk);
        rreq_ready = 1'b0;
        chk({req, " waiting response"}, {30'd0, rrsp_ready, rreq_valid}, 32'd2);
        chk({req, " no done before response"}, {31'd0, cmd_reg[6]}, 32'd0);
        rrsp_valid = 1'b1; rrsp_rdata = rsp;
        @(negedge clk);
        rrsp_valid = 1'b0;
        chk({req, " done after response"}, {31'd0, cmd_reg[6]}, 32'd1);
    endtask

    task automatic t_reset;
        chk("R1 data", data_reg, 32'd0);
        chk("R1 cmd", cmd_reg, 32'd0);
        chk("R1 err/busy/valid", {29'd0, err_sticky, busy, rreq_valid}, 32'd0);
    endtask

    task automatic t_data_only;
        hwr(1'b0, 32'h0000_1234);
        chk("R2 data loaded", data_reg, 32'h0000_1234);
        chk("R2 data write does not start", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_local;
        hwr(1'b0, 32'hCAFE_0001);
        local_cmd("R3 hop1 write", mk(4'd0, 1'b1, 8'd1, 2'd0, 6'd5));
        chk("R4 write no data-ready", {31'd0, cmd_reg[7]}, 32'd0);
        hwr(1'b0, 32'd0);
        local_cmd("R3 hop1 read", mk(4'd1, 1'b1, 8'd1, 2'd0, 6'd5));
        chk("R3 read data", data_reg, 32'hCAFE_0001);
        chk("R3 read data-ready", {31'd0, cmd_reg[7]}, 32'd1);
        local_cmd("R3 hop0 read", mk(4'd1, 1'b1, 8'd0, 2'd0, 6'd5));
        chk("R3 hops separate", data_reg, 32'd0);
    endtask

    task automatic t_phy;
        hwr(1'b0, 32'd0);
        local_cmd("R5 phyctl hi=0", mk(4'd0, 1'b1, 8'd0, 2'd0, 6'd7));
        hwr(1'b0, 32'h0000_0011);
        local_cmd("R5 phy write", mk(4'd0, 1'b1, 8'd0, 2'd3, 6'd2));
        hwr(1'b0, 32'd0);
        local_cmd("R5 phy read", mk(4'd1, 1'b1, 8'd0, 2'd3, 6'd2));
        chk("R5 phy read data", data_reg, 32'h0000_0011);
        hwr(1'b0, 32'h0800_0000);
        local_cmd("R5 phyctl hi=1", mk(4'd0, 1'b1, 8'd0, 2'd0, 6'd7));
        remote_cmd("R5 R9 remote phy read", mk(4'd1, 1'b0, 8'd2, 2'd3, 6'd2),
                   2'd1, 8'd2, 8'h42, 32'h0800_0000, 32'h0000_0077);
        chk("R9 read data", data_reg, 32'h0000_0077);
        chk("R9 data-ready", {31'd0, cmd_reg[7]}, 32'd1);
    endtask

    task automatic t_remote_write;
        hwr(1'b0, 32'h0000_D00D);
        remote_cmd("R8 remote write", mk(4'd0, 1'b0, 8'd2, 2'd0, 6'd4),
                   2'd0, 8'd2, 8'd4, 32'h0000_D00D, 32'hFFFF_FFFF);
        chk("R8 no data-ready", {31'd0, cmd_reg[7]}, 32'd0);
        chk("R8 data kept", data_reg, 32'h0000_D00D);
    endtask

    task automatic t_circ;
        hwr(1'b0, 32'h0000_5A5A);
        remote_cmd("R10 circular", mk(4'd3, 1'b0, 8'd1, 2'd0, 6'd3),
                   2'd3, 8'd1, 8'd3, 32'h0000_5A5A, 32'd0);
        hwr(1'b0, 32'd0);
        local_cmd("R10 local copy read", mk(4'd1, 1'b1, 8'd1, 2'd0, 6'd3));
        chk("R10 local copy data", data_reg, 32'h0000_5A5A);
    endtask

    task automatic t_assign;
        hwr(1'b0, 32'h0002_0202);
        remote_cmd("R11 assign", mk(4'd2, 1'b1, 8'd0, 2'd0, 6'd2),
                   2'd2, 8'd0, 8'd2, 32'h0002_0202, 32'd0);
        chk("R11 no error so far", {31'd0, err_sticky}, 32'd0);
    endtask

    task automatic t_busy;
        logic [31:0] cmd;
        cmd = mk(4'd0, 1'b0, 8'd2, 2'd0, 6'd1);
        hwr(1'b0, 32'h0000_BEEF);
        hwr(1'b1, cmd);
        @(negedge clk);
        chk("R7 in request", {31'd0, rreq_valid}, 32'd1);
        hwr(1'b1, mk(4'd1, 1'b1, 8'd0, 2'd0, 6'd0));
        chk("R7 cmd unchanged", cmd_reg, cmd);
        hwr(1'b0, 32'h1111_1111);
        chk("R7 data unchanged", data_reg, 32'h0000_BEEF);
        chk("R7 error set", {31'd0, err_sticky}, 32'd1);
        chk("R7 R12 wdata intact", rreq_wdata, 32'h0000_BEEF);
        rreq_ready = 1'b1;
        @(negedge clk);
        rreq_ready = 1'b0;
        rrsp_valid = 1'b1;
        @(negedge clk);
        rrsp_valid = 1'b0;
        chk("R7 op still completes", {31'd0, cmd_reg[6]}, 32'd1);
    endtask

    task automatic t_bad;
        hwr(1'b0, 32'hFFFF_FFFF);
        local_cmd("R6 bad hop read", mk(4'd1, 1'b1, 8'd5, 2'd0, 6'd0));
        chk("R6 bad hop zero", data_reg, 32'd0);
        chk("R6 bad hop ready", {31'd0, cmd_reg[7]}, 32'd1);
        local_cmd("R6 bad offset write", mk(4'd0, 1'b1, 8'd0, 2'd0, 6'd40));
        chk("R6 bad write no ready", {31'd0, cmd_reg[7]}, 32'd0);
        local_cmd("R6 unknown sub", mk(4'd9, 1'b1, 8'd0, 2'd0, 6'd0));
        chk("R6 unknown sub no ready", {31'd0, cmd_reg[7]}, 32'd0);
        hwr(1'b0, 32'hFFFF_FFFF);
        local_cmd("R6 bad space read", mk(4'd1, 1'b1, 8'd0, 2'd1, 6'd0));
        chk("R6 bad space zero", data_reg, 32'd0);
        hwr(1'b0, 32'hFFFF_FFFF);
        local_cmd("R6 R5 phy hi=1 read", mk(4'd1, 1'b1, 8'd0, 2'd3, 6'd2));
        chk("R6 R5 out-of-range phy zero", data_reg, 32'd0);
        chk("R6 error held", {31'd0, err_sticky}, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_only();
        t_local();
        t_phy();
        t_remote_write();
        t_circ();
        t_assign();
        t_busy();
        t_bad();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule